// File: doc/BRIEF.md
# Inbound Message Queue Status and Interrupt Unit

This unit keeps the status and interrupt state of a circular queue of inbound message slots. It counts the messages held from push and pop strobes. It tracks whether a message operation is under way from start, done and error strobes. It exposes a five-bit status word that software reads and clears bit by bit with write-one-to-clear writes. A control word turns the queue on and off, enables each interrupt source and sets an occupancy threshold.

There are two sticky interrupt sources. One fires when the queue reaches its last free slot. The other fires when the number of held messages reaches the programmed threshold. The single interrupt output follows either sticky bit. When the controller is switched off, the occupancy is emptied and the empty bit is forced high, but any interrupt already latched stays latched until software clears it. The unit carries no message data and handles no descriptors.

Top module: `msgq_stat_irq`

## Requirements
- R1: While `rst_n` is low, and until the second rising clock edge after it goes high, the status word reads 5'b00010 (only empty set), `irq_o` is 0, and the control word is all zero.
- R2: Status word bit positions: bit 0 threshold interrupt, bit 1 empty, bit 2 busy, bit 3 always reads 0, bit 4 full interrupt.
- R3: While enabled, a push is accepted only when the count is below DEPTH and a pop only when the count is above zero, both on the same edge if both are valid. The count never exceeds DEPTH. Bit 1 reads 1 exactly when the count is zero.
- R4: On the edge where the count goes from below DEPTH to DEPTH while enabled with the full-interrupt enable set, bit 4 becomes 1.
- R5: On the edge where the count changes to equal a nonzero threshold while enabled with the threshold-interrupt enable set, bit 0 becomes 1. A threshold of zero never sets bit 0.
- R6: A status write clears bit 0 or bit 4 where its data holds a 1. Zero data bits, and data bits 1 to 3, have no effect. A set condition on the same edge as a clear leaves the bit at 1.
- R7: While the enable is 0, bit 1 reads 1, the count is held at zero, pushes and pops are ignored, and bits 0 and 4 keep their value.
- R8: Bit 2 (busy) becomes 1 after a start strobe. It becomes 0 after a done or an error strobe. A start on the same edge as a done or an error leaves it at 1. It cannot be written.
- R9: `irq_o` equals the OR of status bits 0 and 4 at all times.
- R10: Control word fields: bit 0 enable, bit 1 threshold-interrupt enable, bit 2 full-interrupt enable, bits [3 +: CNT_W] threshold. A write with `cfg_we` takes effect from the next edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 3+CNT_W | Control word write data |
| stat_we | input | 1 | Status write-one-to-clear strobe |
| stat_wdata | input | 5 | Status write data |
| stat_rdata | output | 5 | Status word |
| q_push | input | 1 | A message was added to the queue |
| q_pop | input | 1 | A message was removed from the queue |
| msg_start | input | 1 | A message operation begins |
| msg_done | input | 1 | The message operation finished |
| msg_err | input | 1 | The message operation ended with an error |
| irq_o | output | 1 | Interrupt request |

## Verification
Directed sequences first fill the queue past a threshold of three, then to the last slot, and push once more while full. This separates the threshold event from the full event and shows that a push at full is refused. Clear writes with zeros, with the read-only bits set, and together with a new full event show apart the clear, the no-op and set-wins cases. A disable in the middle of a run shows that the count drops while the sticky bits stay. A threshold of zero shows that the threshold source is off. A long random run then mixes pushes, pops, busy strobes, clears and control writes. It reaches the full boundary, the empty boundary and simultaneous push and pop at both ends, and each status bit is compared against a bench model on every cycle.

// File: rtl/msgq_pkg.sv
package msgq_pkg;
  localparam int ST_W      = 5;
  localparam int ST_THR    = 0;
  localparam int ST_EMPTY  = 1;
  localparam int ST_BUSY   = 2;
  localparam int ST_RSVD   = 3;
  localparam int ST_FULL   = 4;

  localparam int CTL_EN    = 0;
  localparam int CTL_TIE   = 1;
  localparam int CTL_FIE   = 2;
  localparam int CTL_THR   = 3;
endpackage

// File: rtl/msgq_rst_sync.sv
module msgq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/msgq_occupancy.sv
module msgq_occupancy #(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             push,
  input  logic             pop,
  output logic [CNT_W-1:0] cnt_q,
  output logic [CNT_W-1:0] cnt_nxt
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic push_ok, pop_ok;

  always_comb begin
    push_ok = push && (cnt_q != FULL_CNT);
    pop_ok  = pop  && (cnt_q != '0);
    if (!run)
      cnt_nxt = '0;
    else if (push_ok && !pop_ok)
      cnt_nxt = cnt_q + CNT_W'(1);
    else if (pop_ok && !push_ok)
      cnt_nxt = cnt_q - CNT_W'(1);
    else
      cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/msgq_flag.sv
module msgq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic q
);
  logic q_nxt;

  always_comb q_nxt = set | (q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/msgq_stat_irq.sv
module msgq_stat_irq
  import msgq_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int CTRL_W = CTL_THR + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              stat_we,
  input  logic [ST_W-1:0]   stat_wdata,
  output logic [ST_W-1:0]   stat_rdata,
  input  logic              q_push,
  input  logic              q_pop,
  input  logic              msg_start,
  input  logic              msg_done,
  input  logic              msg_err,
  output logic              irq_o
);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic              rst_n_i;
  logic [CTRL_W-1:0] ctrl_q, ctrl_nxt;
  logic              ctrl_en, ctrl_tie, ctrl_fie;
  logic [CNT_W-1:0]  ctrl_thr;
  logic [CNT_W-1:0]  cnt_q, cnt_nxt;
  logic              full_set, thr_set;
  logic              full_clr, thr_clr, busy_clr;
  logic              full_irq, thr_irq, busy;
  logic              unused_wbits;

  msgq_rst_sync u_rst_sync (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i));

  // control word register with explicit clock enable
  always_comb ctrl_nxt = cfg_we ? cfg_wdata : ctrl_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) ctrl_q <= '0;
    else          ctrl_q <= ctrl_nxt;
  end

  assign ctrl_en  = ctrl_q[CTL_EN];
  assign ctrl_tie = ctrl_q[CTL_TIE];
  assign ctrl_fie = ctrl_q[CTL_FIE];
  assign ctrl_thr = ctrl_q[CTL_THR +: CNT_W];

  msgq_occupancy #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n_i), .run(ctrl_en),
    .push(q_push), .pop(q_pop), .cnt_q(cnt_q), .cnt_nxt(cnt_nxt)
  );

  // edge events: the count arrives at a level it did not hold before
  always_comb begin
    full_set = ctrl_en && ctrl_fie && (cnt_nxt == FULL_CNT) && (cnt_q != FULL_CNT);
    thr_set  = ctrl_en && ctrl_tie && (ctrl_thr != '0) &&
               (cnt_nxt == ctrl_thr) && (cnt_q != ctrl_thr);
    full_clr = stat_we && stat_wdata[ST_FULL];
    thr_clr  = stat_we && stat_wdata[ST_THR];
    busy_clr = msg_done || msg_err;
  end

  assign unused_wbits = ^stat_wdata[ST_RSVD:ST_EMPTY];

  msgq_flag u_full_flag (.clk(clk), .rst_n(rst_n_i), .set(full_set),  .clr(full_clr), .q(full_irq));
  msgq_flag u_thr_flag  (.clk(clk), .rst_n(rst_n_i), .set(thr_set),   .clr(thr_clr),  .q(thr_irq));
  msgq_flag u_busy_flag (.clk(clk), .rst_n(rst_n_i), .set(msg_start), .clr(busy_clr), .q(busy));

  always_comb begin
    stat_rdata           = '0;
    stat_rdata[ST_THR]   = thr_irq;
    stat_rdata[ST_EMPTY] = !ctrl_en || (cnt_q == '0);
    stat_rdata[ST_BUSY]  = busy;
    stat_rdata[ST_FULL]  = full_irq;
  end

  assign irq_o = thr_irq | full_irq;
endmodule

// File: rtl/msgq_stat_irq_chk.sv
module msgq_stat_irq_chk
  import msgq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             stat_we,
  input logic [ST_W-1:0]  stat_wdata,
  input logic [ST_W-1:0]  stat_rdata,
  input logic             msg_start,
  input logic             msg_done,
  input logic             msg_err,
  input logic             irq_o,
  input logic             en,
  input logic [CNT_W-1:0] cnt
);
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(DEPTH));

  p_rsvd_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_rdata[ST_RSVD]);

  p_full_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[ST_FULL] && !(stat_we && stat_wdata[ST_FULL]) |=> stat_rdata[ST_FULL]);

  p_thr_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rdata[ST_THR] && !(stat_we && stat_wdata[ST_THR]) |=> stat_rdata[ST_THR]);

  p_empty_when_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> stat_rdata[ST_EMPTY]);

  p_busy_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_done || msg_err) && !msg_start |=> !stat_rdata[ST_BUSY]);

  p_busy_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    msg_start && $past(rst_n) |=> stat_rdata[ST_BUSY] || !$past(rst_n, 1));

  p_irq_or_r9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (stat_rdata[ST_THR] | stat_rdata[ST_FULL]));
endmodule

bind msgq_stat_irq msgq_stat_irq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n_i), .stat_we(stat_we), .stat_wdata(stat_wdata),
  .stat_rdata(stat_rdata), .msg_start(msg_start), .msg_done(msg_done),
  .msg_err(msg_err), .irq_o(irq_o), .en(ctrl_en), .cnt(cnt_q)
);

// File: tb/msgq_stat_irq_tb.sv
module msgq_stat_irq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int CTRL_W = 3 + CNT_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [CTRL_W-1:0] cfg_wdata = '0;
  logic stat_we = 1'b0;
  logic [4:0] stat_wdata = '0;
  logic [4:0] stat_rdata;
  logic q_push = 1'b0, q_pop = 1'b0, msg_start = 1'b0, msg_done = 1'b0, msg_err = 1'b0;
  logic irq_o;

  int checks = 0;
  int errors = 0;

  // bench model
  int m_cnt = 0;
  bit m_qfi = 0, m_miqi = 0, m_busy = 0, m_en = 0, m_fie = 0, m_tie = 0;
  int m_thr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msgq_stat_irq #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .stat_we(stat_we), .stat_wdata(stat_wdata), .stat_rdata(stat_rdata),
    .q_push(q_push), .q_pop(q_pop), .msg_start(msg_start), .msg_done(msg_done),
    .msg_err(msg_err), .irq_o(irq_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [CTRL_W-1:0] ctl(bit en, bit tie, bit fie, int thr);
    logic [CTRL_W-1:0] w;
    w = '0;
    w[0] = en; w[1] = tie; w[2] = fie;
    w[3 +: CNT_W] = CNT_W'(thr);
    return w;
  endfunction

  function automatic logic [4:0] exp_stat();
    return {m_qfi, 1'b0, m_busy, (!m_en || m_cnt == 0), m_miqi};
  endfunction

  // one clock with given inputs; model advances, outputs compared at negedge
  task automatic cyc(bit push, bit pop, bit st, bit dn, bit er,
                     bit swe, logic [4:0] swd, bit cwe, logic [CTRL_W-1:0] cwd);
    bit pok, ook, sf, sthr;
    int nc;
    logic [4:0] e;
    q_push = push; q_pop = pop; msg_start = st; msg_done = dn; msg_err = er;
    stat_we = swe; stat_wdata = swd; cfg_we = cwe; cfg_wdata = cwd;
    @(posedge clk);
    pok = m_en && push && m_cnt != DEPTH;
    ook = m_en && pop && m_cnt != 0;
    nc  = m_en ? m_cnt + int'(pok) - int'(ook) : 0;
    sf  = m_en && m_fie && nc == DEPTH && m_cnt != DEPTH;
    sthr = m_en && m_tie && m_thr != 0 && nc == m_thr && m_cnt != m_thr;
    m_qfi  = sf   | (m_qfi  & ~(swe & swd[4]));
    m_miqi = sthr | (m_miqi & ~(swe & swd[0]));
    m_busy = st | (m_busy & ~(dn | er));
    m_cnt = nc;
    if (cwe) begin
      m_en = cwd[0]; m_tie = cwd[1]; m_fie = cwd[2]; m_thr = int'(cwd[3 +: CNT_W]);
    end
    @(negedge clk);
    e = exp_stat();
    chk(stat_rdata[0] == e[0], "R5 threshold bit", stat_rdata[0], e[0]);
    chk(stat_rdata[1] == e[1], "R3/R7 empty bit", stat_rdata[1], e[1]);
    chk(stat_rdata[2] == e[2], "R8 busy bit", stat_rdata[2], e[2]);
    chk(stat_rdata[3] == 1'b0, "R2 reserved bit", stat_rdata[3], 0);
    chk(stat_rdata[4] == e[4], "R4 full bit", stat_rdata[4], e[4]);
    chk(irq_o == (e[0] | e[4]), "R9 irq", irq_o, e[0] | e[4]);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0,0,0,0,0, 0,5'd0, 0,'0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(stat_rdata == 5'b00010, "R1 reset status", stat_rdata, 5'b00010);
    chk(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
    rst_n = 1'b1;
    // strobes in the synchronising window are not seen
    @(negedge clk);
    chk(stat_rdata == 5'b00010, "R1 release window", stat_rdata, 5'b00010);
    idle(3);
    // R10: enable, both interrupt enables, threshold 3
    cyc(0,0,0,0,0, 0,5'd0, 1, ctl(1,1,1,3));
    for (int i = 0; i < 3; i++) cyc(1,0,0,0,0, 0,5'd0, 0,'0);
    chk(stat_rdata[0] == 1'b1, "R5 threshold reached at 3", stat_rdata[0], 1);
    chk(stat_rdata[4] == 1'b0, "R4 not full at 3", stat_rdata[4], 0);
    for (int i = 0; i < 5; i++) cyc(1,0,0,0,0, 0,5'd0, 0,'0);
    chk(stat_rdata[4] == 1'b1, "R4 full set at DEPTH", stat_rdata[4], 1);
    cyc(1,0,0,0,0, 0,5'd0, 0,'0); // push at full refused (R3)
    // R6: zero bits and read-only bits ignored
    cyc(0,0,0,0,0, 1,5'b01110, 0,'0);
    chk(stat_rdata == 5'b10001, "R6 zero/readonly write no effect", stat_rdata, 5'b10001);
    cyc(0,0,0,0,0, 1,5'b00001, 0,'0);
    chk(stat_rdata == 5'b10000, "R6 clear threshold bit only", stat_rdata, 5'b10000);
    // R3: drain one after a refused push, count was DEPTH
    cyc(0,1,0,0,0, 0,5'd0, 0,'0);
    // R6: set wins against same-edge clear
    cyc(1,0,0,0,0, 1,5'b10000, 0,'0);
    chk(stat_rdata[4] == 1'b1, "R6 set wins over clear", stat_rdata[4], 1);
    // R7: disable keeps sticky, forces empty
    cyc(0,0,0,0,0, 0,5'd0, 1, ctl(0,1,1,3));
    chk(stat_rdata == 5'b10010, "R7 disabled status", stat_rdata, 5'b10010);
    cyc(1,0,0,0,0, 0,5'd0, 0,'0);
    cyc(0,0,0,0,0, 1,5'b10001, 1, ctl(1,1,0,0));
    chk(stat_rdata == 5'b00010, "R7 count zero after re-enable", stat_rdata, 5'b00010);
    // R5: threshold zero never fires
    for (int i = 0; i < DEPTH; i++) cyc(1,0,0,0,0, 0,5'd0, 0,'0);
    chk(stat_rdata[0] == 1'b0, "R5 zero threshold disabled", stat_rdata[0], 0);
    // R8: busy set/clear, start wins
    cyc(0,0,1,0,0, 0,5'd0, 0,'0);
    cyc(0,0,0,0,1, 0,5'd0, 0,'0);
    chk(stat_rdata[2] == 1'b0, "R8 error clears busy", stat_rdata[2], 0);
    cyc(0,0,1,1,0, 0,5'd0, 0,'0);
    chk(stat_rdata[2] == 1'b1, "R8 start wins over done", stat_rdata[2], 1);
    cyc(0,0,0,0,0, 1,5'b00100, 0,'0);
    chk(stat_rdata[2] == 1'b1, "R8 busy not writable", stat_rdata[2], 1);
    // random phase
    for (int i = 0; i < 4000; i++) begin
      bit cw;
      logic [CTRL_W-1:0] cd;
      cw = ($urandom % 64) == 0;
      cd = ctl(($urandom % 8) != 0, $urandom % 2, $urandom % 2, $urandom % (DEPTH + 2));
      cyc(($urandom % 2) == 0, ($urandom % 3) == 0, ($urandom % 8) == 0,
          ($urandom % 10) == 0, ($urandom % 20) == 0,
          ($urandom % 8) == 0, 5'($urandom), cw, cd);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule